// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus when a target device holds SDA low because it stopped partway through a byte. On a request it takes over both bus pins and runs a fixed routine. First both lines are released. Then SCL is clocked a fixed number of times, so the stuck device can shift out the rest of its byte. Last, a STOP condition is formed by pulling SDA low while SCL is released and then releasing SDA. While the routine runs, `busy` shows that the sequencer owns the pins. A one-cycle `done` pulse marks the end, and the pins then go back to the normal controller, which is unchanged.

Each phase lasts one interval. An interval is a parameterised number of `tick` pulses; with a 1 MHz tick and the default of 10, an interval is about 10 µs. A once-only guard allows one recovery per initialisation. When firmware starts a new initialisation it pulses `rearm`, and that allows one more attempt. A second failure inside the same initialisation is therefore not recovered again.

The controller has six states. In IDLE it owns no pins. REL_START holds both lines released. SCL_LO holds SCL low. SCL_HI holds SCL released. STOP_LO holds SDA low with SCL released. STOP_REL holds both lines released. The transitions are:
- IDLE goes to REL_START on an accepted request.
- REL_START goes to SCL_LO when its interval ends.
- SCL_LO goes to SCL_HI when its interval ends.
- SCL_HI goes back to SCL_LO when its interval ends and pulses remain.
- SCL_HI goes to STOP_LO when its interval ends and the last pulse has been given.
- STOP_LO goes to STOP_REL when its interval ends.
- STOP_REL goes to IDLE when its interval ends, and `done` is raised in that same cycle.

Top module: `i2c_bus_recovery`

## Requirements
- R1: After reset `scl_oe`, `sda_oe`, `busy` and `done` are all 0, and the guard is armed. An enable value of 1 means the line is pulled low.
- R2: A `start_req` that is seen while idle and armed makes `busy` rise on the next cycle. The first interval then holds both lines released.
- R3: Exactly PULSES SCL pulses follow, 9 by default. Each pulse is one interval with `scl_oe`=1 followed by one interval with `scl_oe`=0, and `sda_oe` stays 0 during all of them.
- R4: After the last pulse, `sda_oe` is 1 with `scl_oe` 0 for one interval. Then both lines are released for one interval, which forms the STOP.
- R5: `done` is high for exactly one cycle, which is the last cycle with `busy`=1. On the next cycle `busy` is 0 and both enables are 0.
- R6: A `start_req` that arrives while `busy` is 1 has no effect on the running sequence and does not start a second one.
- R7: An interval lasts HOLD_TICKS cycles in which `tick`=1. Cycles without a tick do not advance the sequence, so a full run takes exactly (3 + 2·PULSES)·HOLD_TICKS ticks.
- R8: After a completed sequence, `start_req` is ignored until `rearm` is pulsed. After the pulse, one more sequence may run.
- R9: `scl_oe` and `sda_oe` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request to start a recovery |
| rearm | input | 1 | New initialisation; re-arms the once-only guard |
| tick | input | 1 | Timebase strobe; one interval is HOLD_TICKS strobes |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Sequencer owns the pins |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions check the following on every cycle:
- the two enables never pull low together;
- both enables are 0 while idle;
- the pins are released when `busy` rises;
- `done` lasts one cycle and hands the pins back on the next cycle;
- PULSES falling edges of SCL have been counted by the time `done` appears.

Only the bench scenarios can show the exact length of each phase, the tick gating of the intervals, requests ignored while busy, and the once-only guard with its re-arm. The bench checks these by comparing each pin segment against a queue of expected segments and by counting ticks while busy.

// File: rtl/rcv_pkg.sv
package rcv_pkg;
    typedef enum logic [2:0] {
        RS_IDLE,
        RS_REL_START,
        RS_SCL_LO,
        RS_SCL_HI,
        RS_STOP_LO,
        RS_STOP_REL
    } rcv_state_e;
endpackage

// File: rtl/rcv_interval_timer.sv
module rcv_interval_timer #(
    parameter int HOLD_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign expire = run && tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rcv_pulse_counter.sv
module rcv_pulse_counter #(
    parameter int PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic step,
    output logic last
);
    localparam int PW = (PULSES > 1) ? $clog2(PULSES) : 1;
    localparam logic [PW-1:0] FINAL = PW'(PULSES - 1);

    logic [PW-1:0] cnt_q;

    assign last = (cnt_q == FINAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_bus_recovery.sv
module i2c_bus_recovery
    import rcv_pkg::*;
#(
    parameter int HOLD_TICKS = 10,
    parameter int PULSES     = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic rearm,
    input  logic tick,
    output logic scl_oe,
    output logic sda_oe,
    output logic busy,
    output logic done
);
    rcv_state_e state_q, state_d;
    logic       armed_q;
    logic       accept;
    logic       run;
    logic       expire;
    logic       pulse_step;
    logic       pulse_last;

    assign run        = (state_q != RS_IDLE);
    assign accept     = start_req && armed_q && !run;
    assign pulse_step = (state_q == RS_SCL_HI) && expire;

    rcv_interval_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick   (tick),
        .expire (expire)
    );

    rcv_pulse_counter #(.PULSES(PULSES)) u_pulses (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .step  (pulse_step),
        .last  (pulse_last)
    );

    // Once-only guard: cleared by an accepted request, set again by rearm.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
        end else if (rearm) begin
            armed_q <= 1'b1;
        end else if (accept) begin
            armed_q <= 1'b0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:      if (accept) state_d = RS_REL_START;
            RS_REL_START: if (expire) state_d = RS_SCL_LO;
            RS_SCL_LO:    if (expire) state_d = RS_SCL_HI;
            RS_SCL_HI:    if (expire) state_d = pulse_last ? RS_STOP_LO : RS_SCL_LO;
            RS_STOP_LO:   if (expire) state_d = RS_STOP_REL;
            RS_STOP_REL:  if (expire) state_d = RS_IDLE;
            default:      state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state_q)
            RS_IDLE:      busy   = 1'b0;
            RS_REL_START: ;
            RS_SCL_LO:    scl_oe = 1'b1;
            RS_SCL_HI:    ;
            RS_STOP_LO:   sda_oe = 1'b1;
            RS_STOP_REL:  done   = expire;
            default:      busy   = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_bus_recovery_chk.sv
module i2c_bus_recovery_chk #(
    parameter int PULSES = 9
) (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic busy,
    input logic done
);
    logic        scl_prev_q;
    int unsigned falls_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b0;
            falls_q    <= 0;
        end else begin
            scl_prev_q <= scl_oe;
            if (!busy) falls_q <= 0;
            else if (scl_oe && !scl_prev_q) falls_q <= falls_q + 1;
        end
    end

    // R9
    never_both_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_oe && sda_oe));

    // R1
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe && !done));

    // R2
    start_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!scl_oe && !sda_oe));

    // R5
    done_handback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R3
    pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (falls_q == PULSES));

    // R4
    stop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> (busy && !scl_oe));
endmodule

bind i2c_bus_recovery i2c_bus_recovery_chk #(.PULSES(PULSES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .busy   (busy),
    .done   (done)
);

// File: tb/i2c_bus_recovery_tb.sv
module i2c_bus_recovery_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 10;
    localparam int NPULSE     = 9;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic rearm = 1'b0;
    logic tick = 1'b1;
    logic scl_oe, sda_oe, busy, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [1:0] pins;
        int         len;
        string      tag;
    } seg_t;
    seg_t exp_q[$];

    bit         sb_en = 1'b1;
    int         tick_div = 1;
    logic [2:0] prev_v = 3'b000;
    int         run_len = 0;
    int         done_cnt = 0;
    bit         done_seen = 1'b0;
    int         busy_ticks = 0;
    int         scl_falls = 0;
    logic       scl_last = 1'b0;

    i2c_bus_recovery #(.HOLD_TICKS(HOLD), .PULSES(NPULSE)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .rearm     (rearm),
        .tick      (tick),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .busy      (busy),
        .done      (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic push_sequence();
        exp_q.push_back('{2'b00, HOLD, "R2"});
        for (int i = 0; i < NPULSE; i++) begin
            exp_q.push_back('{2'b10, HOLD, "R3"});
            exp_q.push_back('{2'b00, HOLD, "R3"});
        end
        exp_q.push_back('{2'b01, HOLD, "R4"});
        exp_q.push_back('{2'b00, HOLD, "R4"});
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start_req = 1'b1;
        @(posedge clk); #1 start_req = 1'b0;
    endtask

    task automatic pulse_rearm();
        @(posedge clk); #1 rearm = 1'b1;
        @(posedge clk); #1 rearm = 1'b0;
    endtask

    task automatic wait_idle();
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // tick driver
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk); #1;
            ph   = (ph + 1) % tick_div;
            tick = (ph == 0);
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            logic [2:0] cur;
            cur = {busy, scl_oe, sda_oe};
            if (done_seen) begin
                // R5: pins handed back the cycle after done
                check(!busy && !scl_oe && !sda_oe, "R5", busy, 0);
                done_seen = 1'b0;
            end
            if (done) begin
                done_cnt++;
                done_seen = 1'b1;
                check(busy == 1'b1, "R5", busy, 1);
            end
            if (busy && tick) busy_ticks++;
            if (busy && scl_oe && !scl_last) scl_falls++;
            scl_last = scl_oe;
            if (cur == prev_v) begin
                run_len++;
            end else begin
                if (prev_v[2] && sb_en) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6", int'(prev_v[1:0]), -1);
                    end else begin
                        seg_t e;
                        e = exp_q.pop_front();
                        check(prev_v[1:0] == e.pins, e.tag, int'(prev_v[1:0]), int'(e.pins));
                        check(run_len == e.len, e.tag, run_len, e.len);
                    end
                end
                prev_v  = cur;
                run_len = 1;
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!scl_oe && !sda_oe, "R1", {scl_oe, sda_oe}, 0);
        check(!busy && !done, "R1", {busy, done}, 0);

        // Normal run with a request while busy (R2, R3, R4, R5, R6)
        push_sequence();
        pulse_start();
        @(negedge clk);
        check(busy == 1'b1, "R2", busy, 1);
        repeat (40) @(posedge clk);
        #1 start_req = 1'b1;
        @(posedge clk); #1 start_req = 1'b0;
        wait_idle();
        repeat (HOLD * 3) @(negedge clk);
        check(busy == 1'b0, "R6", busy, 0);
        check(exp_q.size() == 0, "R6", exp_q.size(), 0);
        check(done_cnt == 1, "R5", done_cnt, 1);

        // Once-only guard (R8)
        begin
            int busy_cycles = 0;
            pulse_start();
            repeat (30) begin
                @(negedge clk);
                if (busy || scl_oe || sda_oe) busy_cycles++;
            end
            check(busy_cycles == 0, "R8", busy_cycles, 0);
        end

        // Re-arm, slow tick (R7, R3)
        pulse_rearm();
        sb_en      = 1'b0;
        tick_div   = 3;
        busy_ticks = 0;
        scl_falls  = 0;
        pulse_start();
        wait_idle();
        check(busy_ticks == (3 + 2*NPULSE)*HOLD, "R7", busy_ticks, (3 + 2*NPULSE)*HOLD);
        check(scl_falls == NPULSE, "R3", scl_falls, NPULSE);
        check(done_cnt == 2, "R8", done_cnt, 2);

        // Re-arm again, full-speed timed run (R8, R2, R3, R4)
        tick_div = 1;
        repeat (5) @(negedge clk);
        sb_en = 1'b1;
        pulse_rearm();
        push_sequence();
        pulse_start();
        wait_idle();
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R8", exp_q.size(), 0);
        check(done_cnt == 3, "R5", done_cnt, 3);
        finish_run();
    end
endmodule